// File: doc/BRIEF.md
# Modulo-5 Counter with Selectable Illegal-Code Recovery

A three-bit synchronous counter that walks five codes, 000 up to 100, and wraps to 000. It advances once per rising clock edge while its enable is high. Three of the eight codes a three-bit register can hold (101, 110, 111) are never part of the cycle. A build-time parameter decides what the counter does if it ever finds itself in one of them. In the minimal setting the next-state logic is the smallest form that treats those codes as don't-cares, and each one finds its own way back into the cycle. In the strict setting every illegal code is sent straight to 000 at the cost of extra gating.

A synchronous load port can force any code, legal or not, so recovery can be exercised on purpose. A terminal-count flag marks the last code of the cycle when the counter is about to wrap. Count bit 2 is the most significant bit.

Top module: `mod5_counter`

## Requirements
- R1: With en high and no reset or load, the count steps 000, 001, 010, 011, 100 and then returns to 000, one step per rising clock edge.
- R2: With RECOVER set to the minimal policy and en high, an illegal code moves on one edge as follows: 101 to 010, 110 to 010, 111 to 100.
- R3: With RECOVER set to the strict policy and en high, each of 101, 110 and 111 moves to 000 on one edge.
- R4: With en, ld and rst all low, the count keeps its value across an edge, whether that value is a legal or an illegal code.
- R5: With ld high and rst low, the next edge puts ld_val into the count whatever en is, so a load wins over counting.
- R6: With rst high, the next edge puts 000 into the count, overriding both ld and en.
- R7: tc is high exactly while the count is 100 and en is high; it is combinational on those two, with no added register delay.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high, highest priority |
| en | input | 1 | Count enable, active high |
| ld | input | 1 | Synchronous load strobe, active high |
| ld_val | input | 3 | Code placed in the count when ld is high |
| cnt | output | 3 | Current count, bit 2 most significant |
| tc | output | 1 | Terminal count: count is 100 and en is high |

## Verification
The bench builds the counter twice side by side: one instance with RECOVER at the minimal policy and one with the strict policy, both fed the same stimulus. That pairing puts both recovery maps, R2 and R3, under the same loaded illegal codes in one run, and it shows that the legal cycle, hold, load, reset priority and terminal flag behave the same whichever policy is chosen.

// File: rtl/mod5_pkg.sv
`timescale 1ns/1ps
package mod5_pkg;

   localparam int CNT_W = 3;
   localparam int MOD_N = 5;
   localparam int LAST  = MOD_N - 1;

   typedef logic [CNT_W-1:0] cnt_t;

   typedef enum logic {
      REC_MINIMAL = 1'b0,
      REC_STRICT  = 1'b1
   } recover_e;

endpackage

// File: rtl/mod5_next.sv
`timescale 1ns/1ps
module mod5_next #(
   parameter mod5_pkg::recover_e RECOVER = mod5_pkg::REC_MINIMAL
) (
   input  mod5_pkg::cnt_t cur,
   output mod5_pkg::cnt_t nxt
);
   logic hi, mid, lo;

   assign hi  = cur[2];
   assign mid = cur[1];
   assign lo  = cur[0];

   generate
      if (RECOVER == mod5_pkg::REC_STRICT) begin : g_strict
         // every unused code is gated by the top bit and falls to zero
         assign nxt[2] = ~hi & mid & lo;
         assign nxt[1] = ~hi & (mid ^ lo);
         assign nxt[0] = ~hi & ~lo;
      end else begin : g_minimal
         // unused codes taken as don't-cares during minimisation
         assign nxt[2] = mid & lo;
         assign nxt[1] = mid ^ lo;
         assign nxt[0] = ~hi & ~lo;
      end
   endgenerate

endmodule

// File: rtl/mod5_state_reg.sv
`timescale 1ns/1ps
module mod5_state_reg (
   input  logic           clk,
   input  logic           rst,
   input  logic           ld,
   input  logic           en,
   input  mod5_pkg::cnt_t ld_val,
   input  mod5_pkg::cnt_t nxt,
   output mod5_pkg::cnt_t q
);
   // priority: reset, then load, then count, else hold
   always_ff @(posedge clk) begin
      if (rst)
         q <= '0;
      else if (ld)
         q <= ld_val;
      else if (en)
         q <= nxt;
   end

endmodule

// File: rtl/mod5_tc.sv
`timescale 1ns/1ps
module mod5_tc (
   input  mod5_pkg::cnt_t q,
   input  logic           en,
   output logic           tc
);
   localparam mod5_pkg::cnt_t LAST_CODE = mod5_pkg::cnt_t'(mod5_pkg::LAST);

   assign tc = en && (q == LAST_CODE);

endmodule

// File: rtl/mod5_counter.sv
`timescale 1ns/1ps
module mod5_counter #(
   parameter mod5_pkg::recover_e RECOVER = mod5_pkg::REC_MINIMAL
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       en,
   input  logic       ld,
   input  logic [2:0] ld_val,
   output logic [2:0] cnt,
   output logic       tc
);
   generate
      if (mod5_pkg::CNT_W != 3 || mod5_pkg::MOD_N != 5) begin : g_cfg_bad
         $error("mod5_counter: equations are fixed to a 3-bit, 5-state cycle");
      end
   endgenerate

   mod5_pkg::cnt_t state_q;
   mod5_pkg::cnt_t state_d;

   mod5_next #(.RECOVER(RECOVER)) u_next (
      .cur (state_q),
      .nxt (state_d)
   );

   mod5_state_reg u_reg (
      .clk    (clk),
      .rst    (rst),
      .ld     (ld),
      .en     (en),
      .ld_val (ld_val),
      .nxt    (state_d),
      .q      (state_q)
   );

   mod5_tc u_tc (
      .q  (state_q),
      .en (en),
      .tc (tc)
   );

   assign cnt = state_q;

endmodule

// File: rtl/mod5_counter_chk.sv
`timescale 1ns/1ps
module mod5_counter_chk #(
   parameter mod5_pkg::recover_e RECOVER = mod5_pkg::REC_MINIMAL
) (
   input logic       clk,
   input logic       rst,
   input logic       en,
   input logic       ld,
   input logic [2:0] ld_val,
   input logic [2:0] cnt,
   input logic       tc
);

   AST_RST_ZERO: assert property (@(posedge clk)
      rst |=> cnt == 3'b000); // R6

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
      ld |=> cnt == $past(ld_val)); // R5

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      (!ld && !en) |=> $stable(cnt)); // R4

   AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
      (!ld && en && cnt < 3'b100) |=> cnt == $past(cnt) + 3'd1); // R1

   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
      (!ld && en && cnt == 3'b100) |=> cnt == 3'b000); // R1

   AST_TC_THEN_WRAP: assert property (@(posedge clk) disable iff (rst)
      (tc && !ld) |=> cnt == 3'b000); // R7

   generate
      if (RECOVER == mod5_pkg::REC_STRICT) begin : g_chk_strict
         AST_ILLEGAL_TO_ZERO: assert property (@(posedge clk) disable iff (rst)
            (!ld && en && cnt > 3'b100) |=> cnt == 3'b000); // R3
      end else begin : g_chk_minimal
         AST_ILLEGAL_REJOIN: assert property (@(posedge clk) disable iff (rst)
            (!ld && en && cnt > 3'b100) |=> (cnt == 3'b010 || cnt == 3'b100)); // R2
      end
   endgenerate

endmodule

bind mod5_counter mod5_counter_chk #(.RECOVER(RECOVER)) u_chk (
   .clk    (clk),
   .rst    (rst),
   .en     (en),
   .ld     (ld),
   .ld_val (ld_val),
   .cnt    (cnt),
   .tc     (tc)
);

// File: tb/sim_mod5_counter.sv
`timescale 1ns/1ps
module sim_mod5_counter;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en  = 1'b0;
   logic       ld  = 1'b0;
   logic [2:0] ld_val = 3'b000;
   logic [2:0] cnt0, cnt1;
   logic       tc0, tc1;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   mod5_counter #(.RECOVER(mod5_pkg::REC_MINIMAL)) u0 (
      .clk(clk), .rst(rst), .en(en), .ld(ld), .ld_val(ld_val),
      .cnt(cnt0), .tc(tc0)
   );

   mod5_counter #(.RECOVER(mod5_pkg::REC_STRICT)) u1 (
      .clk(clk), .rst(rst), .en(en), .ld(ld), .ld_val(ld_val),
      .cnt(cnt1), .tc(tc1)
   );

   typedef struct {
      logic [2:0] c0;
      logic [2:0] c1;
      logic       t0;
      logic       t1;
      string      tag;
   } item_t;

   item_t exp_q[$];
   logic [2:0] m0 = 3'b000;
   logic [2:0] m1 = 3'b000;

   // expected successor, taken from R1, R2 and R3
   function automatic logic [2:0] succ(input logic [2:0] s, input bit strict);
      case (s)
         3'b000: return 3'b001;
         3'b001: return 3'b010;
         3'b010: return 3'b011;
         3'b011: return 3'b100;
         3'b100: return 3'b000;
         3'b101: return strict ? 3'b000 : 3'b010;
         3'b110: return strict ? 3'b000 : 3'b010;
         default: return strict ? 3'b000 : 3'b100;
      endcase
   endfunction

   function automatic logic [2:0] apply(input logic [2:0] s, input bit strict,
                                        input logic r, input logic l,
                                        input logic [2:0] v, input logic e);
      if (r)      return 3'b000;          // R6
      else if (l) return v;               // R5
      else if (e) return succ(s, strict); // R1 R2 R3
      else        return s;               // R4
   endfunction

   task automatic step(input logic r, input logic l, input logic [2:0] v,
                       input logic e, input string tag);
      item_t it;
      @(negedge clk);
      rst = r; ld = l; ld_val = v; en = e;
      m0 = apply(m0, 1'b0, r, l, v, e);
      m1 = apply(m1, 1'b1, r, l, v, e);
      it.c0  = m0;
      it.c1  = m1;
      it.t0  = e && (m0 == 3'b100);   // R7
      it.t1  = e && (m1 == 3'b100);
      it.tag = tag;
      exp_q.push_back(it);
   endtask

   task automatic cmp(input logic [3:0] act, input logic [3:0] exp, input string what,
                      input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%b exp=%b", tag, what, act, exp);
      end
   endtask

   // monitor: a quarter period after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            cmp({1'b0, cnt0}, {1'b0, it.c0}, "u0.cnt", it.tag);
            cmp({1'b0, cnt1}, {1'b0, it.c1}, "u1.cnt", it.tag);
            cmp({3'b0, tc0},  {3'b0, it.t0}, "u0.tc",  it.tag);
            cmp({3'b0, tc1},  {3'b0, it.t1}, "u1.tc",  it.tag);
         end
      end
   end

   initial begin
      step(1'b1, 1'b0, 3'b000, 1'b0, "R6 reset state");
      for (int i = 0; i < 12; i++) step(1'b0, 1'b0, 3'b000, 1'b1, "R1 R7 counting");
      for (int i = 0; i < 3; i++)  step(1'b0, 1'b0, 3'b000, 1'b0, "R4 hold legal");
      step(1'b0, 1'b1, 3'b100, 1'b0, "R5 load with en low");
      step(1'b0, 1'b0, 3'b000, 1'b0, "R7 tc low when en low");
      step(1'b0, 1'b0, 3'b000, 1'b1, "R1 R7 wrap from last");
      step(1'b0, 1'b1, 3'b101, 1'b0, "R5 load 101");
      step(1'b0, 1'b0, 3'b000, 1'b0, "R4 hold illegal");
      step(1'b0, 1'b0, 3'b000, 1'b1, "R2 R3 from 101");
      step(1'b0, 1'b0, 3'b000, 1'b1, "R1 after recovery");
      step(1'b0, 1'b1, 3'b110, 1'b1, "R5 load beats count");
      step(1'b0, 1'b0, 3'b000, 1'b1, "R2 R3 from 110");
      step(1'b0, 1'b0, 3'b000, 1'b1, "R1 after recovery");
      step(1'b0, 1'b1, 3'b111, 1'b1, "R5 load 111");
      step(1'b0, 1'b0, 3'b000, 1'b1, "R2 R3 from 111");
      step(1'b0, 1'b0, 3'b000, 1'b1, "R1 R7 after recovery");
      step(1'b0, 1'b1, 3'b011, 1'b1, "R5 load 011");
      step(1'b1, 1'b1, 3'b110, 1'b1, "R6 reset beats load");
      step(1'b0, 1'b0, 3'b000, 1'b1, "R1 count after reset");
      step(1'b0, 1'b1, 3'b111, 1'b0, "R5 load 111 again");
      step(1'b1, 1'b0, 3'b000, 1'b1, "R6 reset from illegal");
      step(1'b0, 1'b0, 3'b000, 1'b0, "R4 hold after reset");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule